// File: doc/BRIEF.md
# Sector ECC Correction Applier

This block runs after a sector of 512 data bytes has been read into a local byte buffer. It watches a 4-symbol hardware ECC decoder (10 check bytes per sector) and acts on what the decoder reports. Each correction slot from the decoder names a byte inside the sector and an 8-bit flip mask. The block applies it by reading that buffer byte, XOR-ing it with the mask and writing it back. When the decoder says the sector cannot be corrected, the block reads the whole sector. If every byte is 0xFF the sector is erased, and the report is forgiven.

After each report it handles, the block pulses a clear strobe so the decoder can move on. It then waits until the spare-data FIFO holds its full four words and returns one result code for the sector. If the FIFO never fills within a polling budget, it returns a timeout code. In large-page mode a buffer holds four sectors and the sector number selects one of them. In small-page mode the buffer holds one sector.

Top module: `ecc_patch_unit`

## Requirements
- R1: During and after reset, `busy`, `resultValid` and `eccClear` are low, and there is no buffer read or write until `start` is seen.
- R2: If `spareWords` equals 4 before the decoder raises `eccDone`, the sector finishes with code 0 (clean) and no buffer write occurs.
- R3: When `eccDone` is high and `eccFail` is low, each slot with a non-zero mask updates buffer byte `idx` to old value XOR mask. The read of `idx` is followed in the next cycle by the write to `idx`, and the read and write strobes are never high together. The sector result is then code 1 (repaired).
- R4: Slot g of `eccWords` sits in bits [32g+31:32g]. The byte offset is bits 24:16 of the slot, and offset bits above bit 24 are ignored. The mask is bits 7:0. In large-page mode `idx` = 512*sectorNum + offset; in small-page mode `idx` = offset. The erased-sector scan uses the same sector base.
- R5: A slot whose mask is zero causes no buffer write. A report in which every mask is zero ends with code 0.
- R6: When `eccDone` and `eccFail` are both high, the block reads all 512 bytes of the sector, including the last one, and writes nothing. The result is code 2 (error) if any byte differs from 0xFF, otherwise code 0.
- R7: After handling each report, `eccClear` is pulsed for exactly one cycle. No result is given until `spareWords` equals 4.
- R8: If `spareWords` has not reached 4 after POLL_LIMIT waiting cycles, the result is code 3 (timeout). `resultValid` rises POLL_LIMIT cycles after the cycle that captured `start`.
- R9: `start` is ignored while `busy` is high.
- R10: `resultValid` is a one-cycle pulse carrying `resultCode`. An error in one report takes precedence over a repair in another report of the same sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin processing one sector |
| largePage | input | 1 | 1: four sectors per buffer, 0: one sector |
| sectorNum | input | 2 | Sector within the buffer (large-page mode) |
| spareWords | input | 3 | Words held in the spare-data FIFO |
| eccDone | input | 1 | Decoder has a report ready |
| eccFail | input | 1 | Decoder report is uncorrectable |
| eccWords | input | 128 | Four correction slots, offset and mask each |
| eccClear | output | 1 | One-cycle clear of the decoder report |
| bufRdEn | output | 1 | Buffer read strobe |
| bufWrEn | output | 1 | Buffer write strobe |
| bufAddr | output | 11 | Buffer byte address |
| bufWrData | output | 8 | Buffer write byte |
| bufRdData | input | 8 | Buffer read byte, valid one cycle after the read strobe |
| busy | output | 1 | Sector in progress |
| resultValid | output | 1 | Result pulse |
| resultCode | output | 2 | 0 clean, 1 repaired, 2 error, 3 timeout |

## Verification
The hardest case to reach is a sector in which a repair and an uncorrectable report both occur, so that the error must win over an earlier repair. The stimulus gets there with a decoder model that raises a second, failing report after the first clear strobe, over a buffer that holds no 0xFF bytes. A related edge case is a single non-0xFF byte placed at the last address of the sector, which is compared only in the cycle after the last scan read. That byte is paired with a dirty byte in a different sector, which must not affect the result.

// File: rtl/ecc_patch_pkg.sv
package ecc_patch_pkg;

  typedef enum logic [1:0] {
    RES_CLEAN    = 2'd0,
    RES_REPAIRED = 2'd1,
    RES_BAD      = 2'd2,
    RES_TIMEOUT  = 2'd3
  } res_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latch;
    logic slotClr;
    logic slotInc;
    logic rdFix;
    logic wrFix;
    logic scanClr;
    logic scanRd;
    logic pollInc;
  } strobe_t;

endpackage

// File: rtl/ecc_patch_dp.sv
module ecc_patch_dp
  import ecc_patch_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTORS      = 4,
  parameter int SLOTS        = 4,
  parameter int POLL_LIMIT   = 4096,
  parameter int OFF_W        = $clog2(SECTOR_BYTES),
  parameter int SEC_W        = $clog2(SECTORS),
  parameter int AW           = OFF_W + SEC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               largePage,
  input  logic [SEC_W-1:0]   sectorNum,
  input  logic [SLOTS*32-1:0] eccWords,
  input  logic [7:0]         bufRdData,
  output logic               bufRdEn,
  output logic               bufWrEn,
  output logic [AW-1:0]      bufAddr,
  output logic [7:0]         bufWrData,
  output logic               slotEnd,
  output logic               patNonZero,
  output logic               scanLast,
  output logic               pollExpired,
  output logic               dirtyNow
);

  localparam int SLC_W = $clog2(SLOTS + 1);
  localparam int SLI_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic               largeQ;
  logic [SEC_W-1:0]   secQ;
  logic [SLC_W-1:0]   slotIdx;
  logic [OFF_W-1:0]   scanIdx;
  logic [CNT_W-1:0]   pollCnt;
  logic               dirty;
  logic               scanChk;
  logic [31:0]        slotWord [SLOTS];
  logic [31:0]        curWord;
  logic [SEC_W-1:0]   secSel;
  logic [AW-1:0]      fixAddr;
  logic [AW-1:0]      scanAddr;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slotWord[g] = eccWords[g*32 +: 32];
  end

  assign slotEnd    = (slotIdx == SLC_W'(SLOTS));
  assign curWord    = slotEnd ? '0 : slotWord[slotIdx[SLI_W-1:0]];
  assign patNonZero = (curWord[7:0] != 8'h00);
  assign secSel     = largeQ ? secQ : '0;
  assign fixAddr    = {secSel, curWord[16 +: OFF_W]};
  assign scanAddr   = {secSel, scanIdx};

  logic unusedBits;
  assign unusedBits = ^{curWord[31:16+OFF_W], curWord[15:8]};

  assign bufRdEn     = stb.rdFix | stb.scanRd;
  assign bufWrEn     = stb.wrFix;
  assign bufAddr     = (stb.rdFix | stb.wrFix) ? fixAddr : scanAddr;
  assign bufWrData   = bufRdData ^ curWord[7:0];
  assign scanLast    = (scanIdx == OFF_W'(SECTOR_BYTES - 1));
  assign pollExpired = (pollCnt == CNT_W'(POLL_LIMIT - 1));
  assign dirtyNow    = dirty | (scanChk && bufRdData != 8'hFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      largeQ  <= 1'b0;
      secQ    <= '0;
      slotIdx <= '0;
      scanIdx <= '0;
      pollCnt <= '0;
      dirty   <= 1'b0;
      scanChk <= 1'b0;
    end else begin
      scanChk <= stb.scanRd;
      if (stb.latch) begin
        largeQ  <= largePage;
        secQ    <= sectorNum;
        pollCnt <= '0;
      end else if (stb.pollInc) begin
        pollCnt <= pollCnt + CNT_W'(1);
      end
      if (stb.slotClr)      slotIdx <= '0;
      else if (stb.slotInc) slotIdx <= slotIdx + SLC_W'(1);
      if (scanChk && bufRdData != 8'hFF) dirty <= 1'b1;
      if (stb.scanClr) begin
        scanIdx <= '0;
        dirty   <= 1'b0;
      end else if (stb.scanRd) begin
        scanIdx <= scanIdx + OFF_W'(1);
      end
    end
  end

  // R3
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> ($past(bufRdEn) && bufAddr == $past(bufAddr)));

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bufRdEn && bufWrEn));

  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < CNT_W'(POLL_LIMIT));

  // R4
  small_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((bufRdEn || bufWrEn) && !largeQ) |-> (bufAddr[AW-1:OFF_W] == '0));

endmodule

// File: rtl/ecc_patch_ctrl.sv
module ecc_patch_ctrl
  import ecc_patch_pkg::*;
#(
  parameter int SPARE_WORDS = 4,
  parameter int SPW_W       = $clog2(SPARE_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SPW_W-1:0] spareWords,
  input  logic             eccDone,
  input  logic             eccFail,
  input  logic             slotEnd,
  input  logic             patNonZero,
  input  logic             scanLast,
  input  logic             pollExpired,
  input  logic             dirtyNow,
  output strobe_t          stb,
  output logic             eccClear,
  output logic             busy,
  output logic             resultValid,
  output res_e             resultCode
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SLOT, ST_FIXRD, ST_FIXWR, ST_SCAN, ST_SCANEND, ST_CLEAR
  } state_e;

  state_e state, nextState;
  logic   fixedQ, badQ, finish;
  res_e   finCode;
  logic   spareReady;

  assign spareReady = (spareWords == SPW_W'(SPARE_WORDS));
  assign busy       = (state != ST_IDLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    eccClear  = 1'b0;
    finish    = 1'b0;
    finCode   = RES_CLEAN;
    case (state)
      ST_IDLE: if (start) begin
        stb.latch = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (spareReady) begin
          finish    = 1'b1;
          finCode   = badQ ? RES_BAD : (fixedQ ? RES_REPAIRED : RES_CLEAN);
          nextState = ST_IDLE;
        end else if (pollExpired) begin
          finish    = 1'b1;
          finCode   = RES_TIMEOUT;
          nextState = ST_IDLE;
        end else begin
          stb.pollInc = 1'b1;
          if (eccDone) begin
            if (eccFail) begin
              stb.scanClr = 1'b1;
              nextState   = ST_SCAN;
            end else begin
              stb.slotClr = 1'b1;
              nextState   = ST_SLOT;
            end
          end
        end
      end
      ST_SLOT: begin
        if (slotEnd)         nextState   = ST_CLEAR;
        else if (patNonZero) nextState   = ST_FIXRD;
        else                 stb.slotInc = 1'b1;
      end
      ST_FIXRD: begin
        stb.rdFix = 1'b1;
        nextState = ST_FIXWR;
      end
      ST_FIXWR: begin
        stb.wrFix   = 1'b1;
        stb.slotInc = 1'b1;
        nextState   = ST_SLOT;
      end
      ST_SCAN: begin
        stb.scanRd = 1'b1;
        if (scanLast) nextState = ST_SCANEND;
      end
      ST_SCANEND: nextState = ST_CLEAR;
      ST_CLEAR: begin
        eccClear  = 1'b1;
        nextState = ST_WAIT;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      fixedQ      <= 1'b0;
      badQ        <= 1'b0;
      resultValid <= 1'b0;
      resultCode  <= RES_CLEAN;
    end else begin
      state       <= nextState;
      resultValid <= finish;
      if (finish) resultCode <= finCode;
      if (stb.latch) begin
        fixedQ <= 1'b0;
        badQ   <= 1'b0;
      end else begin
        if (stb.wrFix) fixedQ <= 1'b1;
        if (state == ST_SCANEND && dirtyNow) badQ <= 1'b1;
      end
    end
  end

  // R10
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R7
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    eccClear |=> !eccClear);

  // R7
  result_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultCode != RES_TIMEOUT) |->
      ($past(spareWords) == SPW_W'(SPARE_WORDS)));

endmodule

// File: rtl/ecc_patch_unit.sv
module ecc_patch_unit
  import ecc_patch_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTORS      = 4,
  parameter int SLOTS        = 4,
  parameter int SPARE_WORDS  = 4,
  parameter int POLL_LIMIT   = 4096,
  parameter int OFF_W        = $clog2(SECTOR_BYTES),
  parameter int SEC_W        = $clog2(SECTORS),
  parameter int AW           = OFF_W + SEC_W,
  parameter int SPW_W        = $clog2(SPARE_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                largePage,
  input  logic [SEC_W-1:0]    sectorNum,
  input  logic [SPW_W-1:0]    spareWords,
  input  logic                eccDone,
  input  logic                eccFail,
  input  logic [SLOTS*32-1:0] eccWords,
  output logic                eccClear,
  output logic                bufRdEn,
  output logic                bufWrEn,
  output logic [AW-1:0]       bufAddr,
  output logic [7:0]          bufWrData,
  input  logic [7:0]          bufRdData,
  output logic                busy,
  output logic                resultValid,
  output logic [1:0]          resultCode
);

  strobe_t stb;
  logic    slotEnd, patNonZero, scanLast, pollExpired, dirtyNow;
  res_e    code;

  ecc_patch_ctrl #(.SPARE_WORDS(SPARE_WORDS), .SPW_W(SPW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .spareWords(spareWords),
    .eccDone(eccDone), .eccFail(eccFail), .slotEnd(slotEnd),
    .patNonZero(patNonZero), .scanLast(scanLast), .pollExpired(pollExpired),
    .dirtyNow(dirtyNow), .stb(stb), .eccClear(eccClear), .busy(busy),
    .resultValid(resultValid), .resultCode(code)
  );

  ecc_patch_dp #(
    .SECTOR_BYTES(SECTOR_BYTES), .SECTORS(SECTORS), .SLOTS(SLOTS),
    .POLL_LIMIT(POLL_LIMIT), .OFF_W(OFF_W), .SEC_W(SEC_W), .AW(AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .largePage(largePage),
    .sectorNum(sectorNum), .eccWords(eccWords), .bufRdData(bufRdData),
    .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .bufAddr(bufAddr),
    .bufWrData(bufWrData), .slotEnd(slotEnd), .patNonZero(patNonZero),
    .scanLast(scanLast), .pollExpired(pollExpired), .dirtyNow(dirtyNow)
  );

  assign resultCode = code;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!bufRdEn && !bufWrEn && !eccClear));

endmodule

// File: tb/ecc_patch_unit_bench.sv
module ecc_patch_unit_bench;

  localparam int PL = 60;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         largePage = 1'b0;
  logic [1:0]   sectorNum = '0;
  logic [2:0]   spareWords = '0;
  logic         eccDone = 1'b0;
  logic         eccFail = 1'b0;
  logic [127:0] eccWords = '0;
  logic         eccClear, bufRdEn, bufWrEn, busy, resultValid;
  logic [10:0]  bufAddr;
  logic [7:0]   bufWrData;
  logic [7:0]   bufRdData;
  logic [1:0]   resultCode;

  logic         ldEn = 1'b0;
  logic [10:0]  ldAddr = '0;
  logic [7:0]   ldData = '0;
  logic [7:0]   mem [0:2047];
  int           wrCount, pulses;
  int           checks = 0;
  int           errors = 0;

  always #5 clk = ~clk;

  ecc_patch_unit #(.POLL_LIMIT(PL)) u_ecc_patch_unit (
    .clk(clk), .rstN(rstN), .start(start), .largePage(largePage),
    .sectorNum(sectorNum), .spareWords(spareWords), .eccDone(eccDone),
    .eccFail(eccFail), .eccWords(eccWords), .eccClear(eccClear),
    .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .bufAddr(bufAddr),
    .bufWrData(bufWrData), .bufRdData(bufRdData), .busy(busy),
    .resultValid(resultValid), .resultCode(resultCode)
  );

  // buffer model with one-cycle read latency
  always_ff @(posedge clk) begin
    if (ldEn)         mem[ldAddr] <= ldData;
    else if (bufWrEn) mem[bufAddr] <= bufWrData;
    bufRdData <= bufRdEn ? mem[bufAddr] : 8'h00;
    if (!rstN) begin
      wrCount <= 0;
      pulses  <= 0;
    end else begin
      if (bufWrEn)     wrCount <= wrCount + 1;
      if (resultValid) pulses  <= pulses + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fillVal(input int mode, input int a, input int base);
    case (mode)
      0:       return 8'((a * 13 + 7) | 1) & 8'h7F;
      1:       return 8'hFF;
      2:       return (a == base + 511) ? 8'h00 : 8'hFF;
      default: return (a == 1539) ? 8'h00 : 8'hFF;
    endcase
  endfunction

  task automatic fillMem(input int mode, input int base);
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk);
      ldEn = 1'b1; ldAddr = 11'(a); ldData = fillVal(mode, a, base);
    end
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic waitClear(input string req);
    int n = 0;
    while (!eccClear && n < 3000) begin @(negedge clk); n++; end
    chk(eccClear, req, 0, 1);
  endtask

  task automatic waitResult(output logic [1:0] code);
    int n = 0;
    while (!resultValid && n < 3000) begin @(negedge clk); n++; end
    chk(resultValid, "R10 result pulse seen", 0, 1);
    code = resultCode;
    @(negedge clk);
    chk(!resultValid, "R10 pulse is one cycle", 1, 0);
    spareWords = 3'd0;
  endtask

  task automatic runSector(input logic lg, input logic [1:0] sec, input logic [1:0] kind,
                           input logic fl, input logic [127:0] words, output logic [1:0] code);
    int p0;
    @(negedge clk);
    largePage = lg; sectorNum = sec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (kind == 2'd0) begin
      spareWords = 3'd4;
    end else begin
      eccWords = words; eccFail = fl; eccDone = 1'b1;
      waitClear("R7 clear strobe");
      @(negedge clk);
      eccDone = 1'b0; eccFail = 1'b0;
      p0 = pulses;
      repeat (5) @(negedge clk);
      // R7: no result before the spare FIFO is full
      chk(busy && pulses == p0, "R7 waits for spare words", pulses - p0, 0);
      spareWords = 3'd4;
    end
    waitResult(code);
  endtask

  typedef struct packed {
    logic         lg;
    logic [1:0]   sec;
    logic [1:0]   kind;   // 0 spare only, 1 decoder report
    logic         fl;
    logic [1:0]   fill;
    logic [127:0] words;  // {slot3, slot2, slot1, slot0}
    logic [1:0]   exp;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t TABLE [8] = '{
    // R3: three corrections in sector 2, one slot empty
    '{1'b1, 2'd2, 2'd1, 1'b0, 2'd0,
      {32'h0000_00FF, 32'h0, 32'h01FF_0080, 32'h0005_0001}, 2'd1, 4'd3},
    // R4: small page ignores sector and upper offset bit
    '{1'b0, 2'd3, 2'd1, 1'b0, 2'd0,
      {32'h0, 32'h0, 32'h0207_0022, 32'h0064_000F}, 2'd1, 4'd4},
    // R5: all masks zero
    '{1'b1, 2'd1, 2'd1, 1'b0, 2'd0,
      {32'h0, 32'h0, 32'h0020_0000, 32'h0010_0000}, 2'd0, 4'd5},
    // R6: uncorrectable, erased sector, slot ignored
    '{1'b1, 2'd1, 2'd1, 1'b1, 2'd1,
      {32'h0, 32'h0, 32'h0, 32'h0003_0055}, 2'd0, 4'd6},
    // R6: uncorrectable, last byte of sector 1 dirty
    '{1'b1, 2'd1, 2'd1, 1'b1, 2'd2, 128'h0, 2'd2, 4'd6},
    // R4: dirty byte lies in sector 3, scan of sector 1 is clean
    '{1'b1, 2'd1, 2'd1, 1'b1, 2'd3, 128'h0, 2'd0, 4'd4},
    // R4: small page scan covers bytes 0..511
    '{1'b0, 2'd2, 2'd1, 1'b1, 2'd2, 128'h0, 2'd2, 4'd4},
    // R2: spare ready with no report
    '{1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 128'h0, 2'd0, 4'd2}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] code;
    int base, nz, w0, idx, p0, cnt;
    logic [31:0] w;
    logic [7:0] pat;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !resultValid && !eccClear, "R1 in reset", busy, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !resultValid && !eccClear && !bufRdEn && !bufWrEn,
        "R1 after reset", {busy, bufRdEn, bufWrEn}, 0);

    for (int v = 0; v < 8; v++) begin
      base = TABLE[v].lg ? int'(TABLE[v].sec) * 512 : 0;
      fillMem(int'(TABLE[v].fill), base);
      w0 = wrCount;
      runSector(TABLE[v].lg, TABLE[v].sec, TABLE[v].kind, TABLE[v].fl,
                TABLE[v].words, code);
      chk(code == TABLE[v].exp, $sformatf("R%0d vector %0d code", TABLE[v].req, v),
          code, TABLE[v].exp);
      nz = 0;
      for (int s = 0; s < 4; s++) begin
        w = TABLE[v].words[s*32 +: 32];
        pat = w[7:0];
        if (TABLE[v].kind == 2'd1 && !TABLE[v].fl && pat != 8'h00) begin
          nz++;
          idx = base + int'(w[24:16]);
          chk(mem[idx] == (fillVal(int'(TABLE[v].fill), idx, base) ^ pat),
              $sformatf("R3 R4 vector %0d byte %0d", v, idx), mem[idx],
              fillVal(int'(TABLE[v].fill), idx, base) ^ pat);
        end
      end
      // R5 R6 R2: only non-zero masks of correctable reports write
      chk(wrCount - w0 == nz, $sformatf("R5 vector %0d write count", v), wrCount - w0, nz);
    end

    // R8 R9: timeout with a second start while busy
    p0 = pulses;
    @(negedge clk);
    largePage = 1'b1; sectorNum = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!resultValid && cnt < 3000) begin
      @(negedge clk);
      cnt++;
      start = (cnt == 10);
    end
    start = 1'b0;
    chk(resultCode == 2'd3, "R8 timeout code", resultCode, 3);
    chk(cnt == PL, "R8 timeout cycle", cnt, PL);
    repeat (5) @(negedge clk);
    chk(pulses - p0 == 1 && !busy, "R9 start while busy ignored", pulses - p0, 1);

    // R10: repair then dirty uncorrectable report in one sector gives error
    fillMem(0, 0);
    @(negedge clk);
    largePage = 1'b0; sectorNum = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    eccWords = {96'h0, 32'h0004_0011}; eccFail = 1'b0; eccDone = 1'b1;
    waitClear("R7 first clear");
    @(negedge clk);
    eccDone = 1'b0;
    repeat (2) @(negedge clk);
    eccFail = 1'b1; eccDone = 1'b1;
    waitClear("R7 second clear");
    @(negedge clk);
    eccDone = 1'b0; eccFail = 1'b0;
    spareWords = 3'd4;
    waitResult(code);
    chk(code == 2'd2, "R10 error beats repair", code, 2);
    chk(mem[4] == (fillVal(0, 4, 0) ^ 8'h11), "R3 repaired byte kept", mem[4],
        fillVal(0, 4, 0) ^ 8'h11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule